// File: doc/BRIEF.md
# Single-Accumulator Stepped Processor

This block is a very small processor built around one accumulator. It executes a program held in a word-addressed internal memory. Each instruction is 16 bits wide. The top four bits select the operation and the low twelve bits name a memory address or a device. Execution is spelled out as separate register-transfer steps, one per clock:

- A fetch takes three steps: the program counter is copied into the address register, the addressed word is captured into the buffer register while the program counter advances, and the buffer is copied into the instruction register.
- An operand step then follows. Instructions that touch memory need two further steps, in which the operand moves through the buffer register.

The memory is filled from outside through a load port, and this port only works while reset is held. Sixteen word-wide device registers act as the I/O space. A device register can be given a value from outside and read back from outside, and the processor can read or write it with the device instructions. Memory contents can be observed through a combinational peek port. After reset, the program counter starts at a parameterised reset vector. The processor runs until it meets a halt instruction.

Top module: `acc_seq_core`

## Requirements
- R1: While the synchronous active-low reset is low at a clock edge, the accumulator becomes 0, the program counter becomes RESET_VEC and halted is 0; execution starts from RESET_VEC once reset is released.
- R2: An instruction word carries its opcode in bits 15:12 and its operand field in bits 11:0; opcode 1 copies the memory word at the operand address into the accumulator.
- R3: Opcode 5 adds the memory word at the operand address to the accumulator, modulo 2^16, with no carry kept.
- R4: Opcode 2 writes the accumulator into the memory word at the operand address, leaving the accumulator unchanged.
- R5: Opcode 3 loads the accumulator from the device register selected by operand bits 3:0, and opcode 7 writes the accumulator into that device register; operand bits 11:4 play no part in device selection.
- R6: Opcode 0 stops execution: halted rises and stays at 1, and the program counter and accumulator hold, until the next reset.
- R7: Opcodes 4, 6 and 8 to 15 change no accumulator, memory or device state, and execution continues with the next word.
- R8: Memory-referencing instructions (opcodes 1, 2, 5) take 6 clock cycles, and all others take 4. The program counter changes only by +1, on the second cycle of each fetch, so it still shows RESET_VEC one cycle after reset is released and RESET_VEC+1 one cycle later.
- R9: The program counter wraps from 0xFFF to 0x000.
- R10: The memory load port writes only while reset is low; a load-port write during execution leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_we | input | 1 | Memory load-port write enable (effective only in reset) |
| ld_addr | input | 12 | Memory load-port address |
| ld_data | input | 16 | Memory load-port data |
| peek_addr | input | 12 | Memory observation address |
| peek_data | output | 16 | Memory word at peek_addr (combinational) |
| dev_set_we | input | 1 | External write enable for a device register |
| dev_set_sel | input | 4 | Device register selected for external write |
| dev_set_data | input | 16 | Data for external device write |
| dev_view_sel | input | 4 | Device register selected for observation |
| dev_view_data | output | 16 | Contents of the observed device register |
| acc | output | 16 | Accumulator |
| pc | output | 12 | Program counter |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Each instruction runs as the middle of a three-word program: a load seeds the accumulator, the instruction under test follows, and a halt ends the run. This lets the final accumulator, the memory word, the device register and the cycle count show apart load, add, store, device read, device write and no-op behaviour. The add patterns include a carry out of bit 15, which separates modulo arithmetic from a widened or saturating sum. A device read with nonzero high operand bits tells apart decoding on four bits and decoding on the whole field. A long run of no-ops across the top of memory exposes any program counter that fails to wrap. Sampling the program counter on the first two cycles after reset shows whether the increment falls on the right fetch step.

// File: rtl/acc_seq_pkg.sv
// Package: shared constants and types of the stepped accumulator processor.
// Assumes a 4-bit opcode in the top bits of every instruction word.
package acc_seq_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_HALT = 4'h0;
    localparam logic [OPC_W-1:0] OPC_LDM  = 4'h1;
    localparam logic [OPC_W-1:0] OPC_STM  = 4'h2;
    localparam logic [OPC_W-1:0] OPC_LDIO = 4'h3;
    localparam logic [OPC_W-1:0] OPC_ADDM = 4'h5;
    localparam logic [OPC_W-1:0] OPC_STIO = 4'h7;

    // One micro-step per clock.
    typedef enum logic [2:0] {
        ST_FADDR,   // program counter to address register
        ST_FREAD,   // memory to buffer, counter advances
        ST_FLOAD,   // buffer to instruction register
        ST_OPND,    // operand step / device transfer / halt decision
        ST_XFER,    // buffer loads from memory or accumulator
        ST_FINISH,  // memory write or accumulator update
        ST_STOP     // halted
    } step_e;

    // Register-transfer strobes issued by the controller.
    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic mbr_from_mem;
        logic mbr_from_acc;
        logic pc_inc;
        logic ir_from_mbr;
        logic acc_from_mbr;
        logic acc_add_mbr;
        logic acc_from_dev;
        logic dev_from_acc;
        logic mem_write;
    } ctl_s;

endpackage

// File: rtl/acc_seq_ctrl.sv
// Module: micro-step sequencer. Walks the fetch steps, then the operand
// steps selected by the opcode, and issues one set of transfer strobes
// per cycle. Assumes the opcode input comes from the instruction register,
// valid from ST_OPND onward.
module acc_seq_ctrl
    import acc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    output ctl_s             ctl,
    output logic             stopped
);

    step_e step_q, step_d;

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= ST_FADDR;
        else        step_q <= step_d;
    end

    function automatic logic is_mem_op(input logic [OPC_W-1:0] op);
        return (op == OPC_LDM) || (op == OPC_STM) || (op == OPC_ADDM);
    endfunction

    // Next step and strobes for the current step.
    always_comb begin
        ctl    = '0;
        step_d = step_q;
        unique case (step_q)
            ST_FADDR: begin
                ctl.mar_from_pc = 1'b1;
                step_d          = ST_FREAD;
            end
            ST_FREAD: begin
                ctl.mbr_from_mem = 1'b1;
                ctl.pc_inc       = 1'b1;
                step_d           = ST_FLOAD;
            end
            ST_FLOAD: begin
                ctl.ir_from_mbr = 1'b1;
                step_d          = ST_OPND;
            end
            ST_OPND: begin
                if (is_mem_op(opcode)) begin
                    ctl.mar_from_ir = 1'b1;
                    step_d          = ST_XFER;
                end else if (opcode == OPC_LDIO) begin
                    ctl.acc_from_dev = 1'b1;
                    step_d           = ST_FADDR;
                end else if (opcode == OPC_STIO) begin
                    ctl.dev_from_acc = 1'b1;
                    step_d           = ST_FADDR;
                end else if (opcode == OPC_HALT) begin
                    step_d = ST_STOP;
                end else begin
                    step_d = ST_FADDR;
                end
            end
            ST_XFER: begin
                if (opcode == OPC_STM) ctl.mbr_from_acc = 1'b1;
                else                   ctl.mbr_from_mem = 1'b1;
                step_d = ST_FINISH;
            end
            ST_FINISH: begin
                if (opcode == OPC_STM)      ctl.mem_write    = 1'b1;
                else if (opcode == OPC_LDM) ctl.acc_from_mbr = 1'b1;
                else                        ctl.acc_add_mbr  = 1'b1;
                step_d = ST_FADDR;
            end
            ST_STOP: step_d = ST_STOP;
            default: step_d = ST_FADDR;
        endcase
    end

    assign stopped = (step_q == ST_STOP);

endmodule

// File: rtl/acc_seq_mem.sv
// Module: program/data memory. Synchronous write, combinational read on
// two ports (processor address and observation address). Assumes the
// caller multiplexes the single write port. Contents are not reset.
module acc_seq_mem #(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [WORD_W-1:0] peek_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] words [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) words[waddr] <= wdata;
    end

    assign rdata     = words[raddr];
    assign peek_data = words[peek_addr];

endmodule

// File: rtl/acc_seq_iodev.sv
// Module: bank of device registers forming the I/O space. Each register
// can be written by the processor or from outside; a processor write wins
// when both target the same register in one cycle. Registers are not reset.
module acc_seq_iodev #(
    parameter int DEV_W  = 4,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              cpu_we,
    input  logic [DEV_W-1:0]  cpu_sel,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic              ext_we,
    input  logic [DEV_W-1:0]  ext_sel,
    input  logic [WORD_W-1:0] ext_wdata,
    input  logic [DEV_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_data,
    input  logic [DEV_W-1:0]  view_sel,
    output logic [WORD_W-1:0] view_data
);

    localparam int NDEV = 1 << DEV_W;

    logic [WORD_W-1:0] regs [NDEV];

    for (genvar g = 0; g < NDEV; g++) begin : g_dev
        // One device register with processor priority.
        always_ff @(posedge clk) begin
            if (cpu_we && cpu_sel == DEV_W'(g))      regs[g] <= cpu_wdata;
            else if (ext_we && ext_sel == DEV_W'(g)) regs[g] <= ext_wdata;
        end
    end

    assign rd_data   = regs[rd_sel];
    assign view_data = regs[view_sel];

endmodule

// File: rtl/acc_seq_core.sv
// Module: top of the stepped accumulator processor. Holds the programmer
// registers (PC, ACC) and transfer registers (MAR, MBR, IR), applies the
// controller strobes, and owns the memory and device bank. Assumes the
// memory is preloaded through the load port while rst_n is low.
module acc_seq_core
    import acc_seq_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                WORD_W    = 16,
    parameter int                DEV_W     = 4,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [WORD_W-1:0] peek_data,
    input  logic              dev_set_we,
    input  logic [DEV_W-1:0]  dev_set_sel,
    input  logic [WORD_W-1:0] dev_set_data,
    input  logic [DEV_W-1:0]  dev_view_sel,
    output logic [WORD_W-1:0] dev_view_data,
    output logic [WORD_W-1:0] acc,
    output logic [ADDR_W-1:0] pc,
    output logic              halted
);

    localparam int OPC_LSB = WORD_W - OPC_W;

    logic [ADDR_W-1:0] mar;
    logic [WORD_W-1:0] mbr;
    logic [WORD_W-1:0] ir;
    ctl_s              ctl;
    logic [WORD_W-1:0] mem_rdata;
    logic [WORD_W-1:0] dev_rdata;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [WORD_W-1:0] mem_wdata;

    acc_seq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .opcode  (ir[OPC_LSB +: OPC_W]),
        .ctl     (ctl),
        .stopped (halted)
    );

    // Load port owns the write port during reset, the processor otherwise.
    always_comb begin
        if (!rst_n) begin
            mem_we    = ld_we;
            mem_waddr = ld_addr;
            mem_wdata = ld_data;
        end else begin
            mem_we    = ctl.mem_write;
            mem_waddr = mar;
            mem_wdata = mbr;
        end
    end

    acc_seq_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
        .clk       (clk),
        .we        (mem_we),
        .waddr     (mem_waddr),
        .wdata     (mem_wdata),
        .raddr     (mar),
        .rdata     (mem_rdata),
        .peek_addr (peek_addr),
        .peek_data (peek_data)
    );

    acc_seq_iodev #(.DEV_W(DEV_W), .WORD_W(WORD_W)) u_io (
        .clk       (clk),
        .cpu_we    (ctl.dev_from_acc),
        .cpu_sel   (ir[DEV_W-1:0]),
        .cpu_wdata (acc),
        .ext_we    (dev_set_we),
        .ext_sel   (dev_set_sel),
        .ext_wdata (dev_set_data),
        .rd_sel    (ir[DEV_W-1:0]),
        .rd_data   (dev_rdata),
        .view_sel  (dev_view_sel),
        .view_data (dev_view_data)
    );

    // Address and buffer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
        end else begin
            if (ctl.mar_from_pc)       mar <= pc;
            else if (ctl.mar_from_ir)  mar <= ir[ADDR_W-1:0];
            if (ctl.mbr_from_mem)      mbr <= mem_rdata;
            else if (ctl.mbr_from_acc) mbr <= acc;
            if (ctl.ir_from_mbr)       ir  <= mbr;
        end
    end

    // Program counter, wrapping at the top of the address space.
    always_ff @(posedge clk) begin
        if (!rst_n)          pc <= RESET_VEC;
        else if (ctl.pc_inc) pc <= pc + 1'b1;
    end

    // Accumulator updates, modulo 2^WORD_W for the sum.
    always_ff @(posedge clk) begin
        if (!rst_n)                acc <= '0;
        else if (ctl.acc_from_mbr) acc <= mbr;
        else if (ctl.acc_add_mbr)  acc <= acc + mbr;
        else if (ctl.acc_from_dev) acc <= dev_rdata;
    end

endmodule

// File: rtl/acc_seq_chk.sv
// Module: property checker for acc_seq_core, attached by bind below.
// Observes only the top-level ports.
module acc_seq_chk #(
    parameter int                ADDR_W    = 12,
    parameter int                WORD_W    = 16,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halted,
    input logic [ADDR_W-1:0] pc,
    input logic [WORD_W-1:0] acc
);

    // R1: first cycle out of reset shows the reset state.
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc == RESET_VEC && acc == '0 && !halted));

    // R6: halted is sticky until reset.
    assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R6: no program counter motion once halted.
    assert_pc_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc));

    // R6: accumulator holds once halted.
    assert_acc_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(acc));

    // R8 / R9: the counter only ever steps by one, modulo its width.
    assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc != $past(pc)) |-> (pc == ADDR_W'($past(pc) + 1'b1)));

endmodule

bind acc_seq_core acc_seq_chk #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .RESET_VEC (RESET_VEC)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .halted (halted),
    .pc     (pc),
    .acc    (acc)
);

// File: tb/acc_seq_core_test.sv
module acc_seq_core_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [11:0] RV = 12'h010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_we = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [11:0] peek_addr = '0;
    logic [15:0] peek_data;
    logic        dev_set_we = 1'b0;
    logic [3:0]  dev_set_sel = '0;
    logic [15:0] dev_set_data = '0;
    logic [3:0]  dev_view_sel = '0;
    logic [15:0] dev_view_data;
    logic [15:0] acc;
    logic [11:0] pc;
    logic        halted;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    acc_seq_core #(.RESET_VEC(RV)) uut (
        .clk(clk), .rst_n(rst_n),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .peek_addr(peek_addr), .peek_data(peek_data),
        .dev_set_we(dev_set_we), .dev_set_sel(dev_set_sel), .dev_set_data(dev_set_data),
        .dev_view_sel(dev_view_sel), .dev_view_data(dev_view_data),
        .acc(acc), .pc(pc), .halted(halted)
    );

    // {seed, instr, operand value, exp acc, exp mem, exp dev, exp cycles}
    localparam int NV = 9;
    localparam logic [103:0] VECS [NV] = '{
        {16'h1234, 16'h1200, 16'hBEEF, 16'hBEEF, 16'hBEEF, 16'hBEEF, 8'd16}, // R2 load
        {16'h1111, 16'h5201, 16'h2222, 16'h3333, 16'h2222, 16'h2222, 8'd16}, // R3 add
        {16'hFFFF, 16'h5202, 16'h0002, 16'h0001, 16'h0002, 16'h0002, 8'd16}, // R3 carry out
        {16'hA5A5, 16'h2203, 16'h0000, 16'hA5A5, 16'hA5A5, 16'h0000, 8'd16}, // R4 store
        {16'h0001, 16'h3005, 16'h7777, 16'h7777, 16'h7777, 16'h7777, 8'd14}, // R5 dev read
        {16'h4321, 16'h700C, 16'h0000, 16'h4321, 16'h0000, 16'h4321, 8'd14}, // R5 dev write
        {16'h5555, 16'hF204, 16'h9999, 16'h5555, 16'h9999, 16'h9999, 8'd14}, // R7 op F
        {16'h0F0F, 16'h4205, 16'h1234, 16'h0F0F, 16'h1234, 16'h1234, 8'd14}, // R7 op 4
        {16'h0000, 16'h3AB6, 16'h6666, 16'h6666, 16'h6666, 16'h6666, 8'd14}  // R5 high bits ignored
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic enter_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic preload(input logic [11:0] a, input logic [15:0] d);
        ld_we = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic dev_set(input logic [3:0] s, input logic [15:0] d);
        dev_set_we = 1'b1; dev_set_sel = s; dev_set_data = d;
        @(negedge clk);
        dev_set_we = 1'b0;
    endtask

    task automatic run_to_halt(output int cyc);
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 20000) begin
            @(posedge clk); #1;
            cyc++;
        end
        if (!halted) chk("watchdog-run", 32'(cyc), 32'hFFFF_FFFF);
        @(negedge clk);
    endtask

    initial begin
        int cyc;
        logic [15:0] acc_h;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 acc", 32'(acc), 32'h0);
        chk("R1 pc", 32'(pc), 32'(RV));
        chk("R1 halted", 32'(halted), 32'h0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            logic [103:0] v;
            logic [15:0] ins;
            v   = VECS[i];
            ins = v[87:72];
            enter_reset();
            preload(RV,          16'h1100);
            preload(RV + 12'd1,  ins);
            preload(RV + 12'd2,  16'h0000);
            preload(12'h100,     v[103:88]);
            preload(ins[11:0],   v[71:56]);
            dev_set(ins[3:0],    v[71:56]);
            run_to_halt(cyc);
            peek_addr    = ins[11:0];
            dev_view_sel = ins[3:0];
            #1;
            chk($sformatf("R2/R3/R5/R7 acc vec%0d", i), 32'(acc), 32'(v[55:40]));
            chk($sformatf("R4 mem vec%0d", i), 32'(peek_data), 32'(v[39:24]));
            chk($sformatf("R5 dev vec%0d", i), 32'(dev_view_data), 32'(v[23:8]));
            chk($sformatf("R8 cycles vec%0d", i), 32'(cyc), 32'(v[7:0]));
        end

        // R6: halt holds state
        acc_h = acc;
        repeat (5) @(negedge clk);
        chk("R6 halted sticky", 32'(halted), 32'h1);
        chk("R6 pc held", 32'(pc), 32'(RV + 12'd3));
        chk("R6 acc held", 32'(acc), 32'(acc_h));

        // R10: load port ignored while running (0x200 holds BEEF from vector 0)
        ld_we = 1'b1; ld_addr = 12'h200; ld_data = 16'hDEAD;
        @(negedge clk);
        ld_we = 1'b0;
        peek_addr = 12'h200;
        #1;
        chk("R10 load ignored", 32'(peek_data), 32'hBEEF);

        // R1: reset after a run clears state
        enter_reset();
        chk("R1 acc after run", 32'(acc), 32'h0);
        chk("R1 pc after run", 32'(pc), 32'(RV));
        chk("R1 halted after run", 32'(halted), 32'h0);

        // R8: increment falls on the second fetch cycle
        preload(RV,          16'h1100);
        preload(RV + 12'd1,  16'h0000);
        preload(12'h100,     16'h4444);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R8 pc cycle1", 32'(pc), 32'(RV));
        @(posedge clk); #1;
        chk("R8 pc cycle2", 32'(pc), 32'(RV + 12'd1));
        cyc = 2;
        while (!halted && cyc < 1000) begin
            @(posedge clk); #1;
            cyc++;
        end
        chk("R8 load+halt cycles", 32'(cyc), 32'd10);
        chk("R2 acc", 32'(acc), 32'h4444);

        // R9: counter wraps through 0xFFF to 0x000
        enter_reset();
        for (int a = 16; a < 4096; a++) preload(12'(a), 16'hF000);
        preload(12'h000, 16'h0000);
        run_to_halt(cyc);
        chk("R9 wrap cycles", 32'(cyc), 32'd16324);
        chk("R9 pc after wrap", 32'(pc), 32'h001);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // Watchdog
    initial begin
        #500us;
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule